// File: doc/BRIEF.md
# SPI Slave with Transmit and Receive FIFOs

This block is the slave end of an SPI link. An external master drives the serial clock and an active-low select line. The block receives 8-bit characters from MOSI and sends 8-bit characters on MISO. Three configuration inputs choose the clock idle level, the edge on which data is sampled, and whether the most or the least significant bit goes first. The serial pins are brought into the system clock domain through two-flop synchronizers, and all sampling and shifting happens on edges detected in that domain.

Software-side logic queues outgoing characters through a parallel write port into a 4-entry transmit FIFO. It collects incoming characters through a parallel read port from a 4-entry receive FIFO. A receive-valid status shows when characters are waiting. When a character completes while the receive FIFO is full, the character is discarded, a sticky overflow flag is set and a one-cycle interrupt pulse is produced. The MISO pin driver is controlled by an output-enable, which is high only while the block is selected.

Top module: `spi_slave_fifo`

## Requirements
- R1: Clock modes. With cfg_cpol=0 the leading SCK edge is rising, and with cfg_cpol=1 it is falling. With cfg_cpha=0 MOSI is sampled on the leading edge and MISO changes on the trailing edge. With cfg_cpha=1 MISO changes on the leading edge and MOSI is sampled on the trailing edge.
- R2: With cfg_lsb_first=0 both directions send bit 7 first. With cfg_lsb_first=1 both directions send bit 0 first.
- R3: miso_oe is high only while select is asserted. It is low, and miso is held at 0, while ss_n is high.
- R4: A falling edge on ss_n clears the receive and transmit shift registers and the bit counter. Bits of an unfinished character are dropped when ss_n rises, and nothing is pushed for them.
- R5: The transmit FIFO holds 4 characters. tx_full is high when 4 are stored, and a write while full is ignored.
- R6: Each outgoing character is loaded from the transmit FIFO head. If the FIFO is empty, 0x00 is sent. With cfg_cpha=0 the first load happens at the select falling edge and each later load happens on the closing edge of the previous character, so a frame of n characters consumes n+1 entries. With cfg_cpha=1 a load happens on the first edge of each character, so a frame of n characters consumes n entries.
- R7: The receive FIFO holds 4 characters in arrival order. rx_rd_data shows the oldest one, rx_rd_en removes it, and rx_valid is high exactly when at least one character is stored.
- R8: A character that completes while the receive FIFO is full is discarded without changing the stored ones. It sets rx_ovf and produces exactly one single-cycle pulse on rx_ovf_irq.
- R9: rx_ovf stays set until a one-cycle pulse on rx_ovf_clr clears it.
- R10: After synchronous reset rx_valid, rx_ovf, rx_ovf_irq, miso_oe and tx_full are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| sck | input | 1 | Serial clock from master |
| ss_n | input | 1 | Active-low select from master |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | MISO pad output enable |
| tx_wr_en | input | 1 | Push tx_wr_data into the transmit FIFO |
| tx_wr_data | input | 8 | Character to transmit |
| tx_full | output | 1 | Transmit FIFO holds 4 characters |
| rx_rd_en | input | 1 | Pop the oldest received character |
| rx_rd_data | output | 8 | Oldest received character |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ovf_clr | input | 1 | Clear the overflow flag |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| rx_ovf_irq | output | 1 | One-cycle pulse per dropped character |

## Verification
The assertions check on every cycle that a full FIFO stays unchanged under a lone write and an empty one stays empty under a lone read. They also check that the bit counter is zero right after a select falling edge, that MISO is quiet whenever its enable is low, that the overflow flag is sticky, and that each interrupt is a single pulse with the flag already set. The bench scenarios show the bit-level framing in all four clock modes and both bit orders. They also show the prefetch count of the transmit FIFO, the discard of a half-received character, the exact content kept after an overflow, and the 0x00 fill for an empty transmit FIFO.

// File: rtl/spis_pkg.sv
package spis_pkg;

  // Serial format selection, gathered from the three configuration inputs
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_cfg_t;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int                 WIDTH   = 3,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_push, do_pop;

  assign do_push = push && (count != FULL_CNT);
  assign do_pop  = pop  && (count != '0);

  // Storage without reset so that it maps onto memory resources
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == $past(count)));  // R5
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);  // R7

endmodule

// File: rtl/spis_engine.sv
module spis_engine
  import spis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spi_cfg_t          cfg,
  input  logic              sck_s,
  input  logic              ss_n_s,
  input  logic              mosi_s,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_head,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_char,
  output logic              miso,
  output logic              miso_oe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              sck_q, ss_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh, rx_next, tx_next, load_val;
  logic              active, ss_fall, rise, fall, lead, trail;
  logic              sample_e, shift_e, out_bit;
  logic              miso_q, oe_q;

  assign active   = !ss_n_s;
  assign ss_fall  = ss_q && !ss_n_s;
  assign rise     = !sck_q && sck_s;
  assign fall     = sck_q && !sck_s;
  assign lead     = cfg.cpol ? fall : rise;
  assign trail    = cfg.cpol ? rise : fall;
  assign sample_e = active && !ss_fall && (cfg.cpha ? trail : lead);
  assign shift_e  = active && !ss_fall && (cfg.cpha ? lead : trail);

  assign load_val = tx_empty ? '0 : tx_head;
  assign rx_next  = cfg.lsb_first ? {mosi_s, rx_sh[DATA_W-1:1]}
                                  : {rx_sh[DATA_W-2:0], mosi_s};
  assign tx_next  = cfg.lsb_first ? {1'b0, tx_sh[DATA_W-1:1]}
                                  : {tx_sh[DATA_W-2:0], 1'b0};
  assign out_bit  = cfg.lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];

  // Load points: select fall in phase-0 modes, first shift edge of a character otherwise
  assign tx_pop  = !tx_empty && ((ss_fall && !cfg.cpha) || (shift_e && bit_cnt == '0));
  assign rx_push = sample_e && (bit_cnt == LAST_BIT);
  assign rx_char = rx_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      ss_q   <= ss_n_s;
      miso_q <= active && out_bit;
      oe_q   <= active;
      if (ss_fall) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= cfg.cpha ? '0 : load_val;
      end else if (!active) begin
        bit_cnt <= '0;
      end else begin
        if (sample_e) begin
          rx_sh   <= rx_next;
          bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
        if (shift_e) tx_sh <= (bit_cnt == '0) ? load_val : tx_next;
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ss_fall |=> (bit_cnt == '0));  // R4
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !miso_oe |-> !miso);  // R3

endmodule

// File: rtl/spi_slave_fifo.sv
module spi_slave_fifo
  import spis_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              tx_wr_en,
  input  logic [DATA_W-1:0] tx_wr_data,
  output logic              tx_full,
  input  logic              rx_rd_en,
  output logic [DATA_W-1:0] rx_rd_data,
  output logic              rx_valid,
  input  logic              rx_ovf_clr,
  output logic              rx_ovf,
  output logic              rx_ovf_irq
);

  spi_cfg_t          cfg;
  logic [2:0]        pins_s;
  logic              tx_empty, tx_pop, rx_push, rx_full, rx_empty, drop;
  logic [DATA_W-1:0] tx_head, rx_char;
  logic              ovf_q, irq_q;

  assign cfg = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

  spis_sync #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({sck, ss_n, mosi}),
    .dout (pins_s)
  );

  spis_engine #(.DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .sck_s    (pins_s[2]),
    .ss_n_s   (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .tx_empty (tx_empty),
    .tx_head  (tx_head),
    .tx_pop   (tx_pop),
    .rx_push  (rx_push),
    .rx_char  (rx_char),
    .miso     (miso),
    .miso_oe  (miso_oe)
  );

  spis_fifo #(.DATA_W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .push  (tx_wr_en),
    .wdata (tx_wr_data),
    .pop   (tx_pop),
    .rdata (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  spis_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .push  (rx_push && !rx_full),
    .wdata (rx_char),
    .pop   (rx_rd_en),
    .rdata (rx_rd_data),
    .empty (rx_empty),
    .full  (rx_full)
  );

  assign drop = rx_push && rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= drop;
      if (drop)            ovf_q <= 1'b1;
      else if (rx_ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign rx_ovf     = ovf_q;
  assign rx_ovf_irq = irq_q;
  assign rx_valid   = !rx_empty;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_ovf && !rx_ovf_clr) |=> rx_ovf);  // R9
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    rx_ovf_irq |-> rx_ovf);  // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_ovf_irq |=> !rx_ovf_irq);  // R8

endmodule

// File: tb/tb_spi_slave_fifo.sv
module tb_spi_slave_fifo;

  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe;
  logic       tx_wr_en = 1'b0;
  logic [7:0] tx_wr_data = '0;
  logic       tx_full;
  logic       rx_rd_en = 1'b0;
  logic [7:0] rx_rd_data;
  logic       rx_valid;
  logic       rx_ovf_clr = 1'b0;
  logic       rx_ovf, rx_ovf_irq;

  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 0;
  logic [7:0] m_tx [8];
  logic [7:0] m_rx [8];
  logic [7:0] txq [$];
  logic [7:0] rxq [$];

  always #10 clk = ~clk;

  spi_slave_fifo dut (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_full(tx_full), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
    .rx_valid(rx_valid), .rx_ovf_clr(rx_ovf_clr), .rx_ovf(rx_ovf),
    .rx_ovf_irq(rx_ovf_irq)
  );

  always @(negedge clk) if (!rst && rx_ovf_irq) irq_cnt++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_bit(input logic b, output logic got);
    if (!cfg_cpha) begin
      mosi = b; tick(HP); got = miso;
      sck = ~cfg_cpol; tick(HP); sck = cfg_cpol;
    end else begin
      sck = ~cfg_cpol; mosi = b; tick(HP); got = miso;
      sck = cfg_cpol; tick(HP);
    end
  endtask

  task automatic run_char(input logic [7:0] mo, output logic [7:0] mi);
    logic g;
    for (int i = 0; i < 8; i++) begin
      int idx = cfg_lsb_first ? i : 7 - i;
      run_bit(mo[idx], g);
      mi[idx] = g;
    end
  endtask

  task automatic sel_on();
    sck = cfg_cpol; tick(4); ss_n = 1'b0; tick(HP);
    chk("R3 oe while selected", miso_oe, 1);
  endtask

  task automatic sel_off();
    tick(HP); ss_n = 1'b1; tick(HP);
    chk("R3 oe after deselect", miso_oe, 0);
    chk("R3 miso quiet", miso, 0);
  endtask

  task automatic wr_tx(input logic [7:0] d);
    chk("R5 tx_full before write", tx_full, (txq.size() == 4) ? 1 : 0);
    tx_wr_en = 1'b1; tx_wr_data = d; tick(1); tx_wr_en = 1'b0;
    if (txq.size() < 4) txq.push_back(d);
  endtask

  task automatic run_frame(int n, string tag);
    int drops = 0, irq0;
    logic [7:0] exp;
    irq0 = irq_cnt;
    sel_on();
    for (int k = 0; k < n; k++) run_char(m_tx[k], m_rx[k]);
    sel_off();
    for (int k = 0; k < n; k++) begin
      exp = (txq.size() > 0) ? txq.pop_front() : 8'h00;
      chk($sformatf("R6 R1 R2 %s miso char %0d", tag, k), m_rx[k], exp);
      if (rxq.size() < 4) rxq.push_back(m_tx[k]);
      else drops++;
    end
    if (!cfg_cpha && txq.size() > 0) void'(txq.pop_front());
    chk({"R8 irq pulses ", tag}, irq_cnt - irq0, drops);
  endtask

  task automatic drain_rx(string tag);
    while (rxq.size() > 0) begin
      chk({"R7 rx_valid ", tag}, rx_valid, 1);
      chk({"R7 R1 R2 rx data ", tag}, rx_rd_data, rxq.pop_front());
      rx_rd_en = 1'b1; tick(1); rx_rd_en = 1'b0;
    end
    chk({"R7 rx empty ", tag}, rx_valid, 0);
  endtask

  initial begin
    logic g;
    void'($urandom(32'd20240611));
    tick(4); rst = 1'b0; tick(1);
    chk("R10 rx_valid", rx_valid, 0);
    chk("R10 rx_ovf", rx_ovf, 0);
    chk("R10 irq", rx_ovf_irq, 0);
    chk("R10 miso_oe", miso_oe, 0);
    chk("R10 tx_full", tx_full, 0);

    // Every mode and bit order, directed data
    for (int m = 0; m < 8; m++) begin
      cfg_cpol = m[0]; cfg_cpha = m[1]; cfg_lsb_first = m[2];
      wr_tx(8'hC1 ^ 8'(m)); wr_tx(8'h5E + 8'(m));
      m_tx[0] = 8'hB4; m_tx[1] = 8'h29 ^ 8'(m);
      run_frame(2, $sformatf("mode%0d", m));
      drain_rx($sformatf("mode%0d", m));
    end

    // Empty transmit FIFO sends zeros
    cfg_cpol = 0; cfg_cpha = 1; cfg_lsb_first = 0;
    m_tx[0] = 8'hFF;
    run_frame(1, "R6 empty");
    drain_rx("R6 empty");

    // Transmit FIFO capacity, fifth write ignored
    for (int i = 0; i < 4; i++) wr_tx(8'h10 + 8'(i));
    chk("R5 tx_full at 4", tx_full, 1);
    wr_tx(8'hEE);
    for (int i = 0; i < 4; i++) m_tx[i] = 8'h70 + 8'(i);
    run_frame(4, "R5 capacity");
    drain_rx("R5 capacity");
    chk("R5 tx drained", tx_full, 0);

    // Partial character discarded, clean restart
    cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0;
    sel_on();
    for (int i = 0; i < 3; i++) run_bit(1'b1, g);
    sel_off();
    chk("R4 partial not stored", rx_valid, 0);
    wr_tx(8'hA5);
    m_tx[0] = 8'h3C;
    run_frame(1, "R4 restart");
    drain_rx("R4 restart");

    // Overflow
    cfg_cpol = 1; cfg_cpha = 1; cfg_lsb_first = 1;
    for (int i = 0; i < 5; i++) m_tx[i] = 8'h81 + 8'(i * 17);
    run_frame(5, "R8 overflow");
    chk("R8 rx_ovf set", rx_ovf, 1);
    tick(30);
    chk("R9 rx_ovf sticky", rx_ovf, 1);
    drain_rx("R8 kept");
    rx_ovf_clr = 1'b1; tick(1); rx_ovf_clr = 1'b0; tick(1);
    chk("R9 rx_ovf cleared", rx_ovf, 0);

    // Constrained random
    for (int it = 0; it < 16; it++) begin
      int nw, n;
      cfg_cpol = $urandom % 2; cfg_cpha = $urandom % 2; cfg_lsb_first = $urandom % 2;
      nw = $urandom % 4;
      for (int i = 0; i < nw; i++) wr_tx(8'($urandom));
      n = 1 + $urandom % 3;
      for (int i = 0; i < n; i++) m_tx[i] = 8'($urandom);
      run_frame(n, $sformatf("R1 R2 random%0d", it));
      drain_rx($sformatf("random%0d", it));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule